// File: doc/BRIEF.md
# Word-Protected Data Memory

This block is the data store used by the memory stage of a pipelined processor. It holds 16-bit words and keeps one lock bit beside every word. In a given cycle the pipeline presents an operation code, a 32-bit byte-independent word address and the data to write. The block then performs a load, a store, a lock (protect) or a release (free) on the addressed word.

A store aimed at a locked word is dropped. The memory keeps its old contents and a violation strobe pulses for one cycle. A release clears the word's lock bit and wipes its data to zero in the same cycle, whether or not the word was locked. Loads always succeed, including loads from locked words. The array has no reset, so block RAM can be inferred. The lock bits live in flops that a synchronous reset clears all at once.

Top module: `pmem_top`

## Requirements
- R1: `op` is a 3-bit code: 0 idle, 1 load, 2 store, 3 lock, 4 release. The values 5 to 7 behave as idle and change neither data nor lock state.
- R2: A load presents the addressed word on `rd_data` in the cycle after the request. `rd_data` holds its value in every cycle that follows a non-load cycle.
- R3: A store to an unlocked word writes `wr_data` into it, and `viol` stays low.
- R4: A store to a locked word leaves the word unchanged. `viol` is high for exactly the one cycle after that store.
- R5: A lock sets the addressed word's lock bit. Locking a word that is already locked is legal and leaves it locked.
- R6: A release clears the word's lock bit and writes zero into the word in the same cycle, also when the word was unlocked. A released word accepts stores again.
- R7: Loads from a locked word return its stored data, and `viol` stays low.
- R8: Only `addr[11:0]` select one of the 4096 words. The upper address bits are ignored, so addresses that differ only there reach the same word.
- R9: While `rst` is high at a clock edge, every lock bit clears, `rd_data` becomes 0 and `viol` becomes 0.
- R10: `viol` is raised only by a blocked store. Loads, locks, releases and idle cycles never raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation code (see R1) |
| addr | input | 32 | Word address; low 12 bits used |
| wr_data | input | 16 | Store data |
| rd_data | output | 16 | Registered load data |
| viol | output | 1 | Registered one-cycle protection-violation strobe |

## Verification
On every cycle the assertions check four things. A lock request leaves the addressed bit set, and a release leaves it clear. A reset leaves every lock bit zero. A blocked store never reaches the array write enable and is followed by a violation pulse. The violation pulse never appears without a store before it, and the read register holds through non-load cycles. Only the bench's scenarios can show that the data really survives a blocked store and that a release zeroes the word. They also cover address aliasing through the upper bits, the last word of the array, undefined op codes having no effect, and a second reset removing protection from a word locked earlier.

// File: rtl/pmem_pkg.sv
package pmem_pkg;
  typedef enum logic [2:0] {
    MOP_IDLE  = 3'd0,
    MOP_LOAD  = 3'd1,
    MOP_STORE = 3'd2,
    MOP_LOCK  = 3'd3,
    MOP_FREE  = 3'd4
  } mop_e;
endpackage

// File: rtl/pmem_decode.sv
module pmem_decode
  import pmem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hit_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              load_o,
  output logic              store_o,
  output logic              set_o,
  output logic              clr_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o
);
  // R8: word index from the low address bits only
  logic unused_hi;
  generate
    if (ADDR_W > IDX_W) begin : g_hi
      assign unused_hi = ^addr_i[ADDR_W-1:IDX_W];
    end else begin : g_nohi
      assign unused_hi = 1'b0;
    end
  endgenerate
  assign idx_o = addr_i[IDX_W-1:0];

  // R1: unknown codes fall through as idle
  always_comb begin
    load_o  = (op_i == MOP_LOAD);
    store_o = (op_i == MOP_STORE);
    set_o   = (op_i == MOP_LOCK);
    clr_o   = (op_i == MOP_FREE);
  end

  // R3/R4/R6: a store lands only on an unlocked word; a release writes zero
  assign we_o    = (store_o && !hit_i) || clr_o;
  assign wdata_o = clr_o ? '0 : wdata_i;
endmodule

// File: rtl/pmem_guard.sv
module pmem_guard #(
  parameter int IDX_W = 12,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic             store_i,
  output logic             hit_o,
  output logic             exc_o
);
  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
    end else if (set_i) begin
      bits_q[idx_i] <= 1'b1;
    end else if (clr_i) begin
      bits_q[idx_i] <= 1'b0;
    end
  end

  assign hit_o = bits_q[idx_i];

  always_ff @(posedge clk) begin
    if (rst) exc_o <= 1'b0;
    else     exc_o <= store_i && hit_o;
  end

  p_lock_sets_r5: assert property (@(posedge clk) disable iff (rst)
    set_i |=> bits_q[$past(idx_i)]);
  p_free_clears_r6: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !bits_q[$past(idx_i)]);
  p_reset_clears_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bits_q == '0));
  p_exc_source_r10: assert property (@(posedge clk) disable iff (rst)
    exc_o |-> $past(store_i));
endmodule

// File: rtl/pmem_array.sv
module pmem_array #(
  parameter int IDX_W  = 12,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[idx_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (re_i) rdata_o <= mem[idx_i];
  end

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/pmem_top.sv
module pmem_top #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              viol
);
  logic [IDX_W-1:0]  idx;
  logic              load, store, set, clr, we, hit;
  logic [DATA_W-1:0] wdata;

  pmem_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dec (
    .op_i(op), .addr_i(addr), .wdata_i(wr_data), .hit_i(hit),
    .idx_o(idx), .load_o(load), .store_o(store), .set_o(set), .clr_o(clr),
    .we_o(we), .wdata_o(wdata)
  );

  pmem_guard #(.IDX_W(IDX_W)) u_grd (
    .clk(clk), .rst(rst), .idx_i(idx), .set_i(set), .clr_i(clr),
    .store_i(store), .hit_o(hit), .exc_o(viol)
  );

  pmem_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst(rst), .idx_i(idx), .we_i(we), .wdata_i(wdata),
    .re_i(load), .rdata_o(rd_data)
  );

  p_blocked_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    (store && hit) |-> !we);
  p_blocked_flags_r4: assert property (@(posedge clk) disable iff (rst)
    (store && hit) |=> viol);
  p_clean_store_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (store && !hit) |=> !viol);
endmodule

// File: tb/sim_pmem_top.sv
module sim_pmem_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  op;
  logic [31:0] addr;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        viol;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pmem_top u0 (.clk(clk), .rst(rst), .op(op), .addr(addr), .wr_data(wr_data),
               .rd_data(rd_data), .viol(viol));

  localparam logic [2:0] IDL = 3'd0, LD = 3'd1, ST = 3'd2, LK = 3'd3, FR = 3'd4;

  // {req[3:0], op[2:0], addr[31:0], wdata[15:0], exp_rd[15:0], exp_viol}
  function automatic logic [71:0] mk(input logic [3:0] rq, input logic [2:0] o,
      input logic [31:0] a, input logic [15:0] w, input logic [15:0] e, input logic x);
    return {rq, o, a, w, e, x};
  endfunction

  localparam int NV = 24;
  localparam logic [71:0] VEC [NV] = '{
    mk(4'd3,  ST, 32'h0000_0010, 16'hA5A5, 16'h0000, 1'b0), // R3
    mk(4'd2,  LD, 32'h0000_0010, 16'h0000, 16'hA5A5, 1'b0), // R2
    mk(4'd3,  ST, 32'h0000_0011, 16'h1234, 16'h0000, 1'b0), // R3
    mk(4'd2,  LD, 32'h0000_0011, 16'h0000, 16'h1234, 1'b0), // R2
    mk(4'd10, LK, 32'h0000_0010, 16'h0000, 16'h0000, 1'b0), // R10 lock quiet
    mk(4'd4,  ST, 32'h0000_0010, 16'hFFFF, 16'h0000, 1'b1), // R4 blocked
    mk(4'd7,  LD, 32'h0000_0010, 16'h0000, 16'hA5A5, 1'b0), // R7, R4 data kept
    mk(4'd5,  LK, 32'h0000_0010, 16'h0000, 16'h0000, 1'b0), // R5 relock
    mk(4'd5,  ST, 32'h0000_0010, 16'h0000, 16'h0000, 1'b1), // R5 still locked
    mk(4'd4,  ST, 32'h0000_0010, 16'h0BAD, 16'h0000, 1'b1), // R4 back-to-back
    mk(4'd10, FR, 32'h0000_0010, 16'h0000, 16'h0000, 1'b0), // R10 free quiet
    mk(4'd6,  LD, 32'h0000_0010, 16'h0000, 16'h0000, 1'b0), // R6 wiped
    mk(4'd6,  ST, 32'h0000_0010, 16'hBEEF, 16'h0000, 1'b0), // R6 storable
    mk(4'd6,  LD, 32'h0000_0010, 16'h0000, 16'hBEEF, 1'b0), // R6
    mk(4'd6,  FR, 32'h0000_0011, 16'h0000, 16'h0000, 1'b0), // R6 free unlocked
    mk(4'd6,  LD, 32'h0000_0011, 16'h0000, 16'h0000, 1'b0), // R6 zeroed
    mk(4'd8,  ST, 32'hABCD_1020, 16'h7777, 16'h0000, 1'b0), // R8 alias write
    mk(4'd8,  LD, 32'h0000_0020, 16'h0000, 16'h7777, 1'b0), // R8
    mk(4'd8,  LK, 32'hFFFF_F020, 16'h0000, 16'h0000, 1'b0), // R8 alias lock
    mk(4'd8,  ST, 32'h0000_0020, 16'h1111, 16'h0000, 1'b1), // R8 lock hit
    mk(4'd1,  3'd7, 32'h0000_0020, 16'h2222, 16'h0000, 1'b0), // R1 undefined op
    mk(4'd1,  LD, 32'h0000_0020, 16'h0000, 16'h7777, 1'b0), // R1 nothing changed
    mk(4'd3,  ST, 32'h0000_0FFF, 16'h5555, 16'h0000, 1'b0), // R3 last word
    mk(4'd2,  LD, 32'h0000_0FFF, 16'h0000, 16'h5555, 1'b0)  // R2 last word
  };

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // drive at negedge, result is visible at the following negedge
  task automatic step(input logic [2:0] o, input logic [31:0] a, input logic [15:0] w);
    @(negedge clk);
    op = o; addr = a; wr_data = w;
    @(negedge clk);
    op = IDL;
  endtask

  initial begin
    #1000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; op = IDL; addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 rd_data reset", rd_data, 16'h0000);
    chk("R9 viol reset", {15'd0, viol}, 16'h0000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [71:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[71:68], i);
      step(v[67:65], v[64:33], v[32:17]);
      chk({tag, " viol"}, {15'd0, viol}, {15'd0, v[0]});
      if (v[67:65] == LD) chk({tag, " rd_data"}, rd_data, v[16:1]);
    end

    // R2: idle and store cycles leave the read register untouched
    step(IDL, 32'h0000_0010, 16'h0000);
    chk("R2 hold after idle", rd_data, 16'h5555);
    step(ST, 32'h0000_0030, 16'h9999);
    chk("R2 hold after store", rd_data, 16'h5555);

    // R4: pulse lasts one cycle only
    step(ST, 32'h0000_0020, 16'h3333);
    chk("R4 viol pulse", {15'd0, viol}, 16'h0001);
    @(negedge clk);
    chk("R4 viol drops", {15'd0, viol}, 16'h0000);

    // R9: a second reset removes protection from word 0x020
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R9 rd_data after reset", rd_data, 16'h0000);
    step(ST, 32'h0000_0020, 16'h2468);
    chk("R9 store after reset no viol", {15'd0, viol}, 16'h0000);
    step(LD, 32'h0000_0020, 16'h0000);
    chk("R9 store after reset lands", rd_data, 16'h2468);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule